// File: doc/BRIEF.md
# Tomlinson Precoder with Modulo Fold

This block sits on the transmit path right after the 16-level amplitude mapper. It moves the feedback half of a decision-feedback equalizer into the transmitter: every output sample is the present input level minus a weighted sum of the block's own earlier outputs. The weights come from the receiver's equalizer training and are written in before payload transmission starts. The receiver therefore never feeds its own, possibly wrong, decisions back through a filter.

The subtraction can push the result outside the transmit range. A modulo inside the loop folds it back into [-16, +16) with a period of 32 level units. The far end sees a wider set of levels and undoes the fold with a matching modulo.

While the training control is high, symbols go through unchanged, the history is held empty and the weight registers accept writes. While it is low, the filter runs, and one filtered output comes out exactly one clock after each accepted input.

Top module: `tomlinson_precoder`

## Requirements
- R1: After reset, `out_valid_o` is 0, `out_o` is 0, all weights are 0 and the history is empty. A data-mode symbol sent straight after reset therefore comes out equal to its input level.
- R2: With `bypass_i` high, every accepted symbol `sym_i` (5-bit two's complement integer) appears on `out_o` as the same value in Q5.10 format (15-bit two's complement, 10 fraction bits), that is sym*1024, one clock later.
- R3: `out_valid_o` is high in the cycle after, and only after, a cycle with `sym_valid_i` high. This gives exactly one output per accepted symbol.
- R4: With `bypass_i` low, the output for input a is x = fold(floor((a*2^20 - sum over k of c[k]*x[n-1-k]) / 2^10)). Here c[k] is the Q2.10 weight at address k (13-bit two's complement, value/1024), x are earlier outputs in Q5.10 units, and k runs over 0..7.
- R5: fold() maps any value into [-16384, 16383] in Q5.10 units, that is [-16, +16) levels, by adding or subtracting multiples of 32768 (32 levels). Results already in range are unchanged.
- R6: A weight write (`coef_we_i` high) while `bypass_i` is low has no effect on later outputs.
- R7: Any cycle with `bypass_i` high empties the history. The first data-mode output after training depends on that input alone.
- R8: Cycles with `sym_valid_i` low leave `out_o` unchanged and do not advance the history.
- R9: A write with `bypass_i` high stores `coef_data_i` at `coef_addr_i`. The weight at address k multiplies the output produced k+1 accepted symbols earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bypass_i | input | 1 | High: training passthrough, history cleared, weights writable |
| sym_valid_i | input | 1 | Input symbol qualifier |
| sym_i | input | 5 | Signed PAM level (odd values -15..+15) |
| coef_we_i | input | 1 | Weight write strobe (honoured only in training) |
| coef_addr_i | input | 3 | Weight index; index k weights the output k+1 symbols back |
| coef_data_i | input | 13 | Signed Q2.10 weight |
| out_valid_o | output | 1 | Output qualifier, one cycle after `sym_valid_i` |
| out_o | output | 15 | Signed Q5.10 precoded sample in [-16, +16) |

## Verification
The hardest condition to reach is a long run of folded outputs fed back through every tap: the fold only matters when large weights and same-sign levels push the sum well past the range several times in a row. The stimulus gets there with a directed phase that loads all eight weights near the Q2.10 maximum and drives the largest levels, followed by a long random phase with random weights and gaps in the valid input. A second hard case is a weight write during data mode combined with a return to training. It is reached by deliberately sending writes while filtering and then checking the following outputs against a model that keeps the old weights.

// File: rtl/tprec_pkg.sv
package tprec_pkg;

  localparam int unsigned DEF_SYM_W    = 5;
  localparam int unsigned DEF_FRAC_W   = 10;
  localparam int unsigned DEF_COEF_W   = 13;
  localparam int unsigned DEF_NUM_TAPS = 8;

  typedef enum logic {
    MODE_TRAIN = 1'b0,
    MODE_DATA  = 1'b1
  } tprec_mode_e;

  function automatic tprec_mode_e mode_of(input logic train);
    return train ? MODE_TRAIN : MODE_DATA;
  endfunction

endpackage

// File: rtl/tprec_rst_sync.sv
module tprec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/tprec_coef_bank.sv
module tprec_coef_bank #(
  parameter int unsigned NUM_TAPS = 8,
  parameter int unsigned COEF_W   = 13,
  localparam int unsigned ADDR_W  = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [COEF_W-1:0]                 wr_data,
  output logic [NUM_TAPS-1:0][COEF_W-1:0]   coef_o
);

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    logic              sel;
    logic [COEF_W-1:0] coef_d;
    logic [COEF_W-1:0] coef_q;

    always_comb begin
      sel    = wr_en && (wr_addr == ADDR_W'(k));
      coef_d = sel ? wr_data : coef_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        coef_q <= '0;
      end else begin
        coef_q <= coef_d;
      end
    end

    assign coef_o[k] = coef_q;
  end

endmodule

// File: rtl/tprec_hist_line.sv
module tprec_hist_line #(
  parameter int unsigned NUM_TAPS = 8,
  parameter int unsigned X_W      = 15
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clear,
  input  logic                           shift_en,
  input  logic [X_W-1:0]                 x_in,
  output logic [NUM_TAPS-1:0][X_W-1:0]   hist_o
);

  logic [NUM_TAPS-1:0][X_W-1:0] hist_d;
  logic [NUM_TAPS-1:0][X_W-1:0] hist_q;

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_stage
    logic [X_W-1:0] feed;
    if (k == 0) begin : g_head
      assign feed = x_in;
    end else begin : g_body
      assign feed = hist_q[k-1];
    end

    always_comb begin
      if (clear) begin
        hist_d[k] = '0;
      end else if (shift_en) begin
        hist_d[k] = feed;
      end else begin
        hist_d[k] = hist_q[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else begin
      hist_q <= hist_d;
    end
  end

  assign hist_o = hist_q;

endmodule

// File: rtl/tprec_fb_mac.sv
module tprec_fb_mac #(
  parameter int unsigned NUM_TAPS = 8,
  parameter int unsigned COEF_W   = 13,
  parameter int unsigned X_W      = 15,
  parameter int unsigned ACC_W    = 25
) (
  input  logic [NUM_TAPS-1:0][COEF_W-1:0] coef_i,
  input  logic [NUM_TAPS-1:0][X_W-1:0]    hist_i,
  output logic signed [ACC_W-1:0]         fb_sum_o
);

  logic signed [NUM_TAPS-1:0][ACC_W-1:0] prod;

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_mul
    logic signed [COEF_W-1:0] c_s;
    logic signed [X_W-1:0]    h_s;
    assign c_s = $signed(coef_i[k]);
    assign h_s = $signed(hist_i[k]);
    assign prod[k] = ACC_W'(c_s) * ACC_W'(h_s);
  end

  always_comb begin
    fb_sum_o = '0;
    for (int k = 0; k < NUM_TAPS; k++) begin
      fb_sum_o = fb_sum_o + $signed(prod[k]);
    end
  end

endmodule

// File: rtl/tprec_fold.sv
module tprec_fold #(
  parameter int unsigned SYM_W  = 5,
  parameter int unsigned FRAC_W = 10,
  parameter int unsigned ACC_W  = 25,
  localparam int unsigned X_W   = SYM_W + FRAC_W
) (
  input  logic signed [SYM_W-1:0] sym_i,
  input  logic signed [ACC_W-1:0] fb_sum_i,
  output logic signed [X_W-1:0]   x_o
);

  logic signed [ACC_W-1:0] sym_ext;
  logic signed [ACC_W-1:0] acc;

  always_comb begin
    sym_ext = ACC_W'(sym_i) <<< (2 * FRAC_W);
    acc     = sym_ext - fb_sum_i;
    // Arithmetic shift floors the fraction; keeping the low X_W bits
    // is the modulo with a period of 2^SYM_W levels.
    x_o     = X_W'(acc >>> FRAC_W);
  end

endmodule

// File: rtl/tomlinson_precoder.sv
module tomlinson_precoder
  import tprec_pkg::*;
#(
  parameter int unsigned SYM_W    = DEF_SYM_W,
  parameter int unsigned FRAC_W   = DEF_FRAC_W,
  parameter int unsigned COEF_W   = DEF_COEF_W,
  parameter int unsigned NUM_TAPS = DEF_NUM_TAPS,
  localparam int unsigned ADDR_W  = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1,
  localparam int unsigned X_W     = SYM_W + FRAC_W,
  localparam int unsigned ACC_W   = X_W + FRAC_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bypass_i,
  input  logic                     sym_valid_i,
  input  logic signed [SYM_W-1:0]  sym_i,
  input  logic                     coef_we_i,
  input  logic [ADDR_W-1:0]        coef_addr_i,
  input  logic [COEF_W-1:0]        coef_data_i,
  output logic                     out_valid_o,
  output logic signed [X_W-1:0]    out_o
);

  logic                          rst_sync_n;
  tprec_mode_e                   mode;
  logic                          coef_wr;
  logic                          hist_clear;
  logic                          hist_shift;
  logic [NUM_TAPS-1:0][COEF_W-1:0] coef_q;
  logic [NUM_TAPS-1:0][X_W-1:0]    hist_q;
  logic signed [ACC_W-1:0]       fb_sum;
  logic signed [X_W-1:0]         x_fold;
  logic signed [X_W-1:0]         x_pass;
  logic signed [X_W-1:0]         x_sel;
  logic                          out_valid_d;
  logic signed [X_W-1:0]         out_d;
  logic                          out_valid_q;
  logic signed [X_W-1:0]         out_q;

  tprec_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    mode       = mode_of(bypass_i);
    coef_wr    = coef_we_i && (mode == MODE_TRAIN);
    hist_clear = (mode == MODE_TRAIN);
    hist_shift = sym_valid_i && (mode == MODE_DATA);
  end

  tprec_coef_bank #(
    .NUM_TAPS (NUM_TAPS),
    .COEF_W   (COEF_W)
  ) u_coef_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (coef_wr),
    .wr_addr (coef_addr_i),
    .wr_data (coef_data_i),
    .coef_o  (coef_q)
  );

  tprec_hist_line #(
    .NUM_TAPS (NUM_TAPS),
    .X_W      (X_W)
  ) u_hist_line (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clear    (hist_clear),
    .shift_en (hist_shift),
    .x_in     (x_fold),
    .hist_o   (hist_q)
  );

  tprec_fb_mac #(
    .NUM_TAPS (NUM_TAPS),
    .COEF_W   (COEF_W),
    .X_W      (X_W),
    .ACC_W    (ACC_W)
  ) u_fb_mac (
    .coef_i   (coef_q),
    .hist_i   (hist_q),
    .fb_sum_o (fb_sum)
  );

  tprec_fold #(
    .SYM_W  (SYM_W),
    .FRAC_W (FRAC_W),
    .ACC_W  (ACC_W)
  ) u_fold (
    .sym_i    (sym_i),
    .fb_sum_i (fb_sum),
    .x_o      (x_fold)
  );

  // Next-state for the output stage
  always_comb begin
    x_pass      = X_W'(sym_i) <<< FRAC_W;
    x_sel       = (mode == MODE_TRAIN) ? x_pass : x_fold;
    out_valid_d = sym_valid_i;
    out_d       = sym_valid_i ? x_sel : out_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid_q <= 1'b0;
      out_q       <= '0;
    end else begin
      out_valid_q <= out_valid_d;
      out_q       <= out_d;
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_o       = out_q;

endmodule

// File: rtl/tomlinson_precoder_chk.sv
module tomlinson_precoder_chk #(
  parameter int unsigned SYM_W    = 5,
  parameter int unsigned FRAC_W   = 10,
  parameter int unsigned COEF_W   = 13,
  parameter int unsigned NUM_TAPS = 8,
  localparam int unsigned X_W     = SYM_W + FRAC_W
) (
  input logic                            clk,
  input logic                            rst_sync_n,
  input logic                            bypass_i,
  input logic                            sym_valid_i,
  input logic [SYM_W-1:0]                sym_i,
  input logic                            out_valid_o,
  input logic [X_W-1:0]                  out_o,
  input logic [NUM_TAPS-1:0][COEF_W-1:0] coef_q,
  input logic [NUM_TAPS-1:0][X_W-1:0]    hist_q
);

  always @(negedge clk) begin
    if (!rst_sync_n) begin
      // R1
      reset_state_chk: assert (!out_valid_o && out_o == '0 && hist_q == '0 && coef_q == '0);
    end
  end

  // R3
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sym_valid_i |=> out_valid_o);

  // R3
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sym_valid_i |=> !out_valid_o);

  // R2
  train_pass_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sym_valid_i && bypass_i) |=>
      (out_o[X_W-1:FRAC_W] == $past(sym_i) && out_o[FRAC_W-1:0] == '0));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sym_valid_i |=> $stable(out_o));

  // R8
  idle_hist_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!sym_valid_i && !bypass_i) |=> $stable(hist_q));

  // R6
  coef_lock_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bypass_i |=> $stable(coef_q));

  // R7
  train_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bypass_i |=> (hist_q == '0));

endmodule

bind tomlinson_precoder tomlinson_precoder_chk #(
  .SYM_W    (SYM_W),
  .FRAC_W   (FRAC_W),
  .COEF_W   (COEF_W),
  .NUM_TAPS (NUM_TAPS)
) chk_i (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .bypass_i    (bypass_i),
  .sym_valid_i (sym_valid_i),
  .sym_i       (sym_i),
  .out_valid_o (out_valid_o),
  .out_o       (out_o),
  .coef_q      (coef_q),
  .hist_q      (hist_q)
);

// File: tb/tomlinson_precoder_tb_top.sv
module tomlinson_precoder_tb_top;

  localparam int NT   = 8;
  localparam int SW   = 5;
  localparam int FW   = 10;
  localparam int CW   = 13;
  localparam int XW   = SW + FW;
  localparam int AW   = 3;
  localparam longint PERIOD = 64'sd32768;
  localparam longint HALF   = 64'sd16384;

  logic                 clk;
  logic                 rst_n;
  logic                 bypass_i;
  logic                 sym_valid_i;
  logic signed [SW-1:0] sym_i;
  logic                 coef_we_i;
  logic [AW-1:0]        coef_addr_i;
  logic [CW-1:0]        coef_data_i;
  logic                 out_valid_o;
  logic signed [XW-1:0] out_o;

  int     n_vec;
  int     n_bad;
  int     n_fold;
  bit     done;
  longint m_coef [NT];
  longint m_hist [NT];
  longint m_out;
  bit     last_fold;

  tomlinson_precoder dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bypass_i    (bypass_i),
    .sym_valid_i (sym_valid_i),
    .sym_i       (sym_i),
    .coef_we_i   (coef_we_i),
    .coef_addr_i (coef_addr_i),
    .coef_data_i (coef_data_i),
    .out_valid_o (out_valid_o),
    .out_o       (out_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic longint fold_val(longint v);
    longint r;
    r = (v + HALF) % PERIOD;
    if (r < 0) r = r + PERIOD;
    return r - HALF;
  endfunction

  function automatic longint raw_val(longint a);
    longint acc;
    acc = a * 64'sd1048576;
    for (int k = 0; k < NT; k++) acc = acc - m_coef[k] * m_hist[k];
    return acc >>> FW;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // Drive at a falling edge, update the model, check at the next falling edge.
  task automatic step(bit bp, bit v, int sym, bit we, int addr, int data, string req);
    longint u;
    bypass_i    = bp;
    sym_valid_i = v;
    sym_i       = SW'(sym);
    coef_we_i   = we;
    coef_addr_i = AW'(addr);
    coef_data_i = CW'(data);
    last_fold   = 1'b0;
    if (v) begin
      if (bp) begin
        m_out = longint'(sym) * 1024;
      end else begin
        u = raw_val(longint'(sym));
        m_out = fold_val(u);
        last_fold = (u != m_out);
      end
    end
    if (bp) begin
      for (int k = 0; k < NT; k++) m_hist[k] = 0;
    end else if (v) begin
      for (int k = NT - 1; k > 0; k--) m_hist[k] = m_hist[k-1];
      m_hist[0] = m_out;
    end
    if (we && bp) m_coef[addr] = longint'($signed(CW'(data)));
    @(negedge clk);
    check(out_valid_o == v, {req, "/R3 valid"}, longint'(out_valid_o), longint'(v));
    check(longint'(out_o) == m_out, req, longint'(out_o), m_out);
    if (last_fold) begin
      n_fold++;
      // R5: folded result lies in range and differs from raw by k*32768
      check(longint'(out_o) >= -HALF && longint'(out_o) < HALF &&
            ((u - longint'(out_o)) % PERIOD) == 0, "R5 fold", longint'(out_o), m_out);
    end
  endtask

  function automatic int rnd_sym();
    return 2 * int'($urandom_range(0, 15)) - 15;
  endfunction

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_vec, 0);
    summary();
  end

  initial begin
    void'($urandom(32'd20417));
    n_vec = 0; n_bad = 0; n_fold = 0; done = 1'b0;
    for (int k = 0; k < NT; k++) begin m_coef[k] = 0; m_hist[k] = 0; end
    m_out = 0;
    bypass_i = 1'b1; sym_valid_i = 1'b0; sym_i = '0;
    coef_we_i = 1'b0; coef_addr_i = '0; coef_data_i = '0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check(out_valid_o == 1'b0, "R1 valid", longint'(out_valid_o), 0);
    check(out_o == '0, "R1 out", longint'(out_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: weights reset to zero, so data mode passes levels
    step(0, 1, 15, 0, 0, 0, "R1 zero weights");
    step(0, 1, -15, 0, 0, 0, "R1 zero weights");
    step(0, 1, 3, 0, 0, 0, "R1 zero weights");

    // R2: training passthrough with random levels and gaps
    for (int i = 0; i < 24; i++) step(1, ($urandom_range(0, 3) != 0), rnd_sym(), 0, 0, 0, "R2 passthrough");

    // R9: single weight 1.0 at address 0
    step(1, 0, 0, 1, 0, 1024, "R9 load");
    for (int i = 0; i < 6; i++) step(0, 1, 15, 0, 0, 0, "R9 tap0 / R4");

    // R9: move weight to address 2 (three symbols back)
    step(1, 0, 0, 1, 0, 0, "R9 load");
    step(1, 0, 0, 1, 2, 1024, "R9 load");
    step(0, 1, 15, 0, 0, 0, "R7 first after training");
    for (int i = 0; i < 7; i++) step(0, 1, 1, 0, 0, 0, "R9 tap2 / R4");

    // R6: writes in data mode are ignored
    step(0, 0, 0, 1, 2, -1024, "R6 write ignored");
    step(0, 0, 0, 1, 5, 4095, "R6 write ignored");
    for (int i = 0; i < 6; i++) step(0, 1, 7, 1, i % NT, -3000, "R6 after data-mode write");

    // R8: idle cycles hold output and history
    for (int i = 0; i < 4; i++) step(0, 0, 9, 0, 0, 0, "R8 idle hold");
    step(0, 1, -5, 0, 0, 0, "R8 history intact");

    // R5: all weights near the positive maximum, largest levels
    for (int k = 0; k < NT; k++) step(1, 0, 0, 1, k, 4095, "R9 load");
    step(0, 1, 15, 0, 0, 0, "R7 first after training");
    for (int i = 0; i < 40; i++) step(0, 1, (i % 3 == 0) ? -15 : 15, 0, 0, 0, "R5/R4 saturated weights");

    // R4/R5/R7/R8: random weights, random symbols, random gaps, occasional retrain
    for (int blk = 0; blk < 12; blk++) begin
      for (int k = 0; k < NT; k++)
        step(1, $urandom_range(0, 1), rnd_sym(), 1, k, int'($urandom_range(0, 8191)) - 4096, "R9/R2 load");
      step(0, 1, rnd_sym(), 0, 0, 0, "R7 first after training");
      for (int i = 0; i < 250; i++)
        step(0, ($urandom_range(0, 4) != 0), rnd_sym(), $urandom_range(0, 1),
             int'($urandom_range(0, NT - 1)), int'($urandom_range(0, 8191)) - 4096, "R4 random");
    end

    check(n_fold > 0, "R5 fold reached", longint'(n_fold), 1);
    summary();
  end

endmodule